// File: doc/BRIEF.md
# Indexed Interrupt Definition Bank

This block is the interrupt capability of a bridge. It turns a set of incoming interrupt lines into interrupt messages, and each message carries the vector that software programmed for that line. Software reaches the block through two configuration dwords. The first is a selector, which names one internal register. The second is a window, which reads or writes the register the selector names. Each source has two definition words. The low word holds the mask, the polarity, the end-of-interrupt mode and the vector. The high word holds a pass-posted-write bit and a sticky waiting flag.

A source in end-of-interrupt mode is level-triggered. When it fires, it latches its waiting flag and sends a single message. It sends nothing more until software acknowledges it. Software can acknowledge in two ways: by writing the high word with bit 31 set, or by writing a one into a separate acknowledge bitmap. A source whose end-of-interrupt bit is clear is edge-triggered. It sends one message per rising edge of its polarity-adjusted input. Messages appear as a one-cycle strobe with the vector. When several sources are waiting to send, the lowest-numbered source goes first.

Top module: `irq_msg_bank`

## Requirements
- R1: After reset the selector is 0, every source reads masked (low word 0x00000001) with the waiting flag clear, and no message strobe is raised.
- R2: A write to byte address CAP_BASE (default 0x40) loads the selector from bits 23:16 of the written data. A read of that address returns the selector in bits 23:16 and zeros elsewhere.
- R3: Selector 0x01 reads NUM_SRC-1 in bits 23:16 through the window at CAP_BASE+4. Writes to it have no effect.
- R4: Selector 0x10+2n is the low word of source n. Bit 0 is the mask, bit 1 is active-low, bit 5 is end-of-interrupt (level) mode and bits 23:16 are the vector. All other bits read 0.
- R5: Selector 0x11+2n is the high word of source n. Bit 30 is a plain read/write bit. Bit 31 reads the waiting flag. Writing 1 to bit 31 clears the flag, and writing 0 to bit 31 leaves it unchanged.
- R6: A masked source sends no message and never sets its waiting flag.
- R7: An unmasked level source whose adjusted input is high and whose flag is clear sets its flag and sends one message. The strobe is high in the second cycle after the input is sampled, for one cycle. No further message follows until its flag is cleared, and it fires again if the input is still high then.
- R8: An unmasked edge source sends exactly one message per rising edge of its adjusted input, and its waiting flag stays clear.
- R9: The adjusted input is the raw input inverted when active-low is set.
- R10: A write to byte address 0x60+4w clears the waiting flag of source 32w+b for every set data bit b. Zero bits leave their sources untouched.
- R11: Selectors that name no register read 0, and writes through them change nothing. Unused addresses read 0.
- R12: Every read strobe produces a read-valid pulse and its data in the following cycle.
- R13: Messages waiting from several sources leave one per cycle, lowest source number first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgAddr | input | 8 | Byte address, dword aligned |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data, valid with cfgRdValid |
| cfgRdValid | output | 1 | Read data valid, one cycle after cfgRdEn |
| srcIn | input | NUM_SRC | Raw interrupt inputs |
| msgValid | output | 1 | One-cycle message strobe |
| msgVector | output | 8 | Vector of the message |

## Verification
The assertions check four things on every cycle. A source only queues a message if it was unmasked. Only a level-mode source raises its waiting flag. A set flag always drops after an acknowledge. Read-valid tracks the read strobe with one cycle of delay. The bench scenarios are needed for the behaviour that depends on ordering or field layout. These are the exact message timing, the absence of a second message while the flag is set, refiring after an acknowledge on a held input, inversion of active-low edges, the order of simultaneous messages, and readback of every field.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam logic [7:0] IDX_COUNT = 8'h01;
  localparam logic [8:0] IDX_DEF0  = 9'h010;
  localparam logic [5:0] ACK_DW    = 6'h18;   // byte 0x60

  typedef struct packed {
    logic       idxWr;
    logic       loWr;
    logic       hiWr;
    logic       ackWr;
    logic [1:0] ackWord;
    logic [6:0] src;
    logic       rdIdx;
    logic       rdCount;
    logic       rdLo;
    logic       rdHi;
    logic       rdAny;
  } bankStrobe_t;
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int         NUM_SRC  = 8,
  parameter logic [7:0] CAP_BASE = 8'h40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [7:0]  cfgAddr,
  input  logic [7:0]  wrIdx,
  output logic [7:0]  selIdx,
  output bankStrobe_t stb
);
  localparam int         ACK_WORDS = (NUM_SRC + 31) / 32;
  localparam logic [5:0] BASE_DW   = CAP_BASE[7:2];
  localparam logic [5:0] DATA_DW   = BASE_DW + 6'd1;
  localparam logic [5:0] ACK_END   = ACK_DW + 6'(ACK_WORDS);
  localparam logic [8:0] DEF_SPAN  = 9'(2 * NUM_SRC);

  logic [5:0] addrDw;
  logic       hitBase, hitData, hitAck, defValid;
  logic [8:0] defOff;
  logic [5:0] ackOff;

  assign addrDw   = cfgAddr[7:2];
  assign hitBase  = addrDw == BASE_DW;
  assign hitData  = addrDw == DATA_DW;
  assign hitAck   = (addrDw >= ACK_DW) && (addrDw < ACK_END);
  assign defOff   = {1'b0, selIdx} - IDX_DEF0;
  assign defValid = ({1'b0, selIdx} >= IDX_DEF0) && (defOff < DEF_SPAN);
  assign ackOff   = addrDw - ACK_DW;

  always_comb begin
    stb         = '0;
    stb.src     = defOff[7:1];
    stb.ackWord = ackOff[1:0];
    stb.idxWr   = cfgWrEn && hitBase;
    stb.loWr    = cfgWrEn && hitData && defValid && !defOff[0];
    stb.hiWr    = cfgWrEn && hitData && defValid && defOff[0];
    stb.ackWr   = cfgWrEn && hitAck;
    stb.rdIdx   = cfgRdEn && hitBase;
    stb.rdCount = cfgRdEn && hitData && (selIdx == IDX_COUNT);
    stb.rdLo    = cfgRdEn && hitData && defValid && !defOff[0];
    stb.rdHi    = cfgRdEn && hitData && defValid && defOff[0];
    stb.rdAny   = cfgRdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          selIdx <= '0;
    else if (stb.idxWr) selIdx <= wrIdx;
  end

  // R2: the selector only moves on a write to the base dword
  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && hitBase) |=> $stable(selIdx));
endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobe_t        stb,
  input  logic [31:0]        wdata,
  input  logic [7:0]         selIdx,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [31:0]        cfgRdata,
  output logic               cfgRdValid,
  output logic               msgValid,
  output logic [7:0]         msgVector
);
  localparam logic [7:0] LAST_SRC = 8'(NUM_SRC - 1);

  logic [NUM_SRC-1:0] mask, actLow, lvlMode, passPw, waitEoi, prevAdj, pend, grant;
  logic [7:0]         vec [NUM_SRC];
  logic [7:0]         selVec;
  logic               unusedWdata;

  assign unusedWdata = ^wdata;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic selMe, adj, ackHit, fireLvl, fireEdge;
    assign selMe    = stb.src == 7'(g);
    assign adj      = srcIn[g] ^ actLow[g];
    assign ackHit   = (stb.hiWr && selMe && wdata[31]) ||
                      (stb.ackWr && stb.ackWord == 2'(g / 32) && wdata[g % 32]);
    assign fireLvl  = lvlMode[g] && !mask[g] && adj && !waitEoi[g];
    assign fireEdge = !lvlMode[g] && !mask[g] && adj && !prevAdj[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mask[g] <= 1'b1;  actLow[g] <= 1'b0;  lvlMode[g] <= 1'b0;
        passPw[g] <= 1'b0; waitEoi[g] <= 1'b0; prevAdj[g] <= 1'b0;
        pend[g] <= 1'b0;  vec[g] <= '0;
      end else begin
        if (stb.loWr && selMe) begin
          mask[g]    <= wdata[0];
          actLow[g]  <= wdata[1];
          lvlMode[g] <= wdata[5];
          vec[g]     <= wdata[23:16];
        end
        if (stb.hiWr && selMe) passPw[g] <= wdata[30];
        prevAdj[g] <= adj;
        waitEoi[g] <= fireLvl || (waitEoi[g] && !ackHit);
        pend[g]    <= fireLvl || fireEdge || (pend[g] && !grant[g]);
      end
    end

    // R6: a source only queues a message if it was unmasked
    a_r6_mask_gate: assert property (@(posedge clk) disable iff (!rstN)
      (pend[g] && !$past(pend[g])) |-> !$past(mask[g]));
    // R7: only a level-mode source raises its waiting flag
    a_r7_level_flag: assert property (@(posedge clk) disable iff (!rstN)
      $rose(waitEoi[g]) |-> $past(lvlMode[g]));
    // R5 / R10: an acknowledge always drops a set flag
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      (ackHit && waitEoi[g]) |=> !waitEoi[g]);
  end

  always_comb begin
    grant  = '0;
    selVec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant  = '0;
        grant[i] = 1'b1;
        selVec = vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid  <= 1'b0;
      msgVector <= '0;
    end else begin
      msgValid  <= |pend;
      msgVector <= selVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRdValid <= 1'b0;
      cfgRdata   <= '0;
    end else begin
      cfgRdValid <= stb.rdAny;
      cfgRdata   <= '0;
      if (stb.rdIdx)   cfgRdata <= {8'h00, selIdx, 16'h0000};
      if (stb.rdCount) cfgRdata <= {8'h00, LAST_SRC, 16'h0000};
      if (stb.rdLo)    cfgRdata <= {8'h00, vec[stb.src], 10'h000, lvlMode[stb.src],
                                    3'b000, actLow[stb.src], mask[stb.src]};
      if (stb.rdHi)    cfgRdata <= {waitEoi[stb.src], passPw[stb.src], 30'h0};
    end
  end

  // R13: each strobe is backed by a queued message in the cycle before
  a_r13_msg_backed: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $past(|pend));
  // R12: read-valid follows the read strobe by one cycle
  a_r12_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdAny |=> cfgRdValid);
endmodule

// File: rtl/irq_msg_bank.sv
module irq_msg_bank
  import irq_bank_pkg::*;
#(
  parameter int         NUM_SRC  = 8,
  parameter logic [7:0] CAP_BASE = 8'h40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgRdEn,
  input  logic [7:0]         cfgAddr,
  input  logic [31:0]        cfgWdata,
  output logic [31:0]        cfgRdata,
  output logic               cfgRdValid,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               msgValid,
  output logic [7:0]         msgVector
);
  bankStrobe_t stb;
  logic [7:0]  selIdx;

  irq_bank_ctrl #(.NUM_SRC(NUM_SRC), .CAP_BASE(CAP_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .wrIdx(cfgWdata[23:16]), .selIdx(selIdx), .stb(stb)
  );

  irq_bank_dp #(.NUM_SRC(NUM_SRC)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(cfgWdata), .selIdx(selIdx),
    .srcIn(srcIn), .cfgRdata(cfgRdata), .cfgRdValid(cfgRdValid),
    .msgValid(msgValid), .msgVector(msgVector)
  );
endmodule

// File: tb/test_irq_msg_bank.sv
`timescale 1ns/1ps
module test_irq_msg_bank;
  localparam int NSRC = 8;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgRdEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        cfgRdValid, msgValid;
  logic [7:0]  msgVector;
  logic [NSRC-1:0] srcIn = '0;

  int compared = 0, mismatched = 0;
  logic [7:0] expQ[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_msg_bank #(.NUM_SRC(NSRC), .CAP_BASE(8'h40)) i_irq_msg_bank (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .cfgRdValid(cfgRdValid), .srcIn(srcIn), .msgValid(msgValid),
    .msgVector(msgVector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: every message strobe must match the head of the expected queue
  always @(negedge clk) begin
    if (rstN && msgValid && !done) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R6/R7/R8 unexpected message: actual %h expected none", msgVector);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (msgVector !== e) begin
          mismatched++;
          $display("FAIL R13 message order: actual %h expected %h", msgVector, e);
        end
      end
    end
  end

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [31:0] d);
    cfgRdEn = 1'b1; cfgAddr = a;
    @(negedge clk);
    cfgRdEn = 1'b0;
    check("R12 read valid", {31'b0, cfgRdValid}, 32'd1);
    d = cfgRdata;
  endtask

  task automatic selWrite(input logic [7:0] idx, input logic [31:0] d);
    cfgWrite(8'h40, {8'h00, idx, 16'h0});
    cfgWrite(8'h44, d);
  endtask

  task automatic selRead(input logic [7:0] idx, output logic [31:0] d);
    cfgWrite(8'h40, {8'h00, idx, 16'h0});
    cfgRead(8'h44, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 no message after reset", {31'b0, msgValid}, 32'd0);
    cfgRead(8'h40, d);      check("R1 selector reset", d, 32'h0);
    selRead(8'h10, d);      check("R1 low word masked", d, 32'h00000001);
    selRead(8'h11, d);      check("R1 flag clear", d, 32'h0);
    // R3 count register and its write protection
    selRead(8'h01, d);      check("R3 source count", d, 32'h00070000);
    cfgWrite(8'h44, 32'hFFFFFFFF);
    cfgRead(8'h44, d);      check("R3 write ignored", d, 32'h00070000);
    // R2 selector readback
    cfgWrite(8'h40, 32'h00120000);
    cfgRead(8'h40, d);      check("R2 selector readback", d, 32'h00120000);
    // R4 field layout, reserved bits read zero
    selWrite(8'h10, 32'hAB41FFE0);
    selRead(8'h10, d);      check("R4 low word fields", d, 32'h00410020);
    // R7 level fire and exact timing
    expQ.push_back(8'h41);
    srcIn[0] = 1'b1;
    @(negedge clk);         check("R7 no strobe after one edge", {31'b0, msgValid}, 32'd0);
    @(negedge clk);         check("R7 strobe on second edge", {24'b0, msgValid ? msgVector : 8'h00}, 32'h41);
    @(negedge clk);         check("R7 strobe lasts one cycle", {31'b0, msgValid}, 32'd0);
    idle(8);
    selRead(8'h11, d);      check("R7 waiting flag set", d, 32'h80000000);
    // R10 bitmap bit of another source leaves this one waiting
    cfgWrite(8'h60, 32'h00000002);
    selRead(8'h11, d);      check("R10 other bit no effect", d, 32'h80000000);
    // R5 zero in bit 31 keeps the flag, bit 30 is stored
    selWrite(8'h11, 32'h40000000);
    selRead(8'h11, d);      check("R5 pass bit kept flag", d, 32'hC0000000);
    // R5/R7 acknowledge with input held high refires
    expQ.push_back(8'h41);
    selWrite(8'h11, 32'h80000000);
    idle(4);
    selRead(8'h11, d);      check("R7 refire after ack", d, 32'h80000000);
    // R10 bitmap acknowledge
    srcIn[0] = 1'b0;
    cfgWrite(8'h60, 32'h00000001);
    selRead(8'h11, d);      check("R10 bitmap clears flag", d, 32'h0);
    // R8/R9 active-low edge source
    srcIn[1] = 1'b1;
    idle(2);
    selWrite(8'h12, 32'h00520002);
    idle(3);
    expQ.push_back(8'h52);
    srcIn[1] = 1'b0;
    idle(4);
    srcIn[1] = 1'b1;
    idle(4);
    expQ.push_back(8'h52);
    srcIn[1] = 1'b0;
    idle(4);
    selRead(8'h13, d);      check("R8 edge flag stays clear", d, 32'h0);
    // R6 masked level source
    selWrite(8'h14, 32'h00630021);
    srcIn[2] = 1'b1;
    idle(5);
    selRead(8'h15, d);      check("R6 masked flag clear", d, 32'h0);
    srcIn[2] = 1'b0;
    // R13 simultaneous edges, lowest first
    selWrite(8'h16, 32'h00740000);
    selWrite(8'h18, 32'h00750000);
    idle(2);
    expQ.push_back(8'h74);
    expQ.push_back(8'h75);
    srcIn[3] = 1'b1; srcIn[4] = 1'b1;
    idle(6);
    // R11 unimplemented selectors and addresses
    selWrite(8'h20, 32'hFFFFFFFF);
    selRead(8'h20, d);      check("R11 unused selector reads zero", d, 32'h0);
    selRead(8'h05, d);      check("R11 gap selector reads zero", d, 32'h0);
    cfgRead(8'h10, d);      check("R11 unused address reads zero", d, 32'h0);
    selRead(8'h10, d);      check("R11 neighbour untouched", d, 32'h00410020);
    idle(4);
    check("R7/R13 all expected messages seen", expQ.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule